// File: doc/BRIEF.md
# Interrupt Priority Selector

This block picks one winning interrupt line out of up to three banks of 32 lines, for a single interrupt class at a time. Each line has a pending bit, a mask bit, a class bit and a small programmable priority value. The class select input decides which group competes: the normal lines or the fast lines. The block reports the winning line number and a valid flag.

A surrounding controller latches edges and levels, holds the configuration, and feeds all of it in as flat vectors. It reads the winner from this block when it raises the matching interrupt request. The selection is combinational over all lines. The result is held in a register and appears on the outputs one clock after the inputs are sampled.

Top module: `irq_prio_select`

## Requirements
- R1: A line competes only when its pending bit is 1, its mask bit is 0 (a mask bit of 1 blocks the line), and its class bit equals `class_fast_i`. Class bit 1 marks a fast line and class bit 0 a normal line.
- R2: Among competing lines, the line with the numerically smallest priority value wins.
- R3: When several competing lines share the smallest priority, the line with the highest overall index wins, across banks as well as within one bank.
- R4: The reported index is 32 × bank + bit position. Line n uses bit n of each vector and bits [n*PRIO_W +: PRIO_W] of `prio_i`.
- R5: When no line competes, the index output is 0 and the valid output is 0.
- R6: The valid output is 1 whenever at least one line competes, so a real winner on line 0 reads as index 0 with valid 1.
- R7: Lines in banks numbered NUM_BANKS or higher never compete, whatever their inputs.
- R8: Any competing line wins over the empty state, including one at the largest priority value (2^PRIO_W − 1).
- R9: The outputs change on the first rising clock edge after the inputs change. A synchronous reset sets the index to 0 and valid to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| class_fast_i | input | 1 | 1 arbitrates fast lines, 0 arbitrates normal lines |
| pend_i | input | 96 | Pending bit per line |
| mask_i | input | 96 | Mask bit per line, 1 blocks the line |
| fast_i | input | 96 | Class bit per line, 1 marks a fast line |
| prio_i | input | 96*PRIO_W | Priority value per line, smaller value is more urgent |
| win_idx_o | output | 7 | Registered winning line index |
| win_valid_o | output | 1 | Registered flag, 1 when a line won |

## Verification
On every cycle the assertions check four things. A reported winner was eligible in the previous cycle. The index stays inside the enabled banks. An idle result always carries index 0. Reset and the empty case both clear the outputs. Priority ordering, the highest-index tie rule, class filtering and the bank limit compare one line against another, so only the directed scenarios can show them. The scenarios use hand-computed winners, and a second instance with one bank covers the bank limit.

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6,
  localparam int MAX_BANKS = 3,
  localparam int LINES     = 32,
  localparam int TOT       = MAX_BANKS * LINES,
  localparam int IDX_W     = $clog2(TOT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  class_fast_i,
  input  logic [TOT-1:0]        pend_i,
  input  logic [TOT-1:0]        mask_i,
  input  logic [TOT-1:0]        fast_i,
  input  logic [TOT*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic                  win_valid_o
);

  logic [TOT-1:0]    elig;
  logic [TOT-1:0]    cls_match;
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  assign cls_match = class_fast_i ? fast_i : ~fast_i;

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_on
      assign elig[b*LINES +: LINES] = pend_i[b*LINES +: LINES]
                                    & ~mask_i[b*LINES +: LINES]
                                    & cls_match[b*LINES +: LINES];
    end else begin : g_off
      assign elig[b*LINES +: LINES] = '0;
    end
  end

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int n = 0; n < TOT; n++) begin
      if (elig[n] && (!found || prio_i[n*PRIO_W +: PRIO_W] <= best_p)) begin
        found  = 1'b1;
        best_p = prio_i[n*PRIO_W +: PRIO_W];
        best_i = IDX_W'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_idx_o   <= '0;
      win_valid_o <= 1'b0;
    end else begin
      win_idx_o   <= found ? best_i : '0;
      win_valid_o <= found;
    end
  end

  logic [TOT-1:0] elig_q;
  always_ff @(posedge clk) elig_q <= elig;

  // R1
  winner_was_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> (int'(win_idx_o) < TOT && elig_q[win_idx_o]));

  // R7
  idx_in_enabled_banks_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> int'(win_idx_o) < NUM_BANKS * LINES);

  // R5
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !win_valid_o |-> win_idx_o == '0);

  // R5
  empty_gives_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |=> !win_valid_o);

  // R6
  any_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (elig != '0) |=> win_valid_o);

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!win_valid_o && win_idx_o == '0));

endmodule

// File: tb/irq_prio_select_test.sv
module irq_prio_select_test;
  localparam int PW  = 6;
  localparam int TOT = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic class_fast = 1'b0;
  logic [TOT-1:0] pend = '0, mask = '0, fast = '0;
  logic [TOT*PW-1:0] prio = '0;
  logic [6:0] idx3, idx1;
  logic val3, val1;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_prio_select uut (.clk(clk), .rst(rst), .class_fast_i(class_fast),
    .pend_i(pend), .mask_i(mask), .fast_i(fast), .prio_i(prio),
    .win_idx_o(idx3), .win_valid_o(val3));

  irq_prio_select #(.NUM_BANKS(1)) uut_one (.clk(clk), .rst(rst),
    .class_fast_i(class_fast), .pend_i(pend), .mask_i(mask), .fast_i(fast),
    .prio_i(prio), .win_idx_o(idx1), .win_valid_o(val1));

  task automatic chk(string tag, logic av, logic [6:0] ai, logic ev, logic [6:0] ei);
    n_chk++;
    if (av !== ev || ai !== ei) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b idx=%0d, want valid=%0b idx=%0d", tag, av, ai, ev, ei);
    end
  endtask

  task automatic clear_all();
    pend = '0; mask = '0; fast = '0; prio = '0; class_fast = 1'b0;
  endtask

  task automatic setp(int line, int p);
    prio[line*PW +: PW] = PW'(p);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset state", val3, idx3, 1'b0, 7'd0);
    rst = 1'b0;
  endtask

  task automatic t_empty();
    clear_all(); step();
    chk("R5 nothing pending", val3, idx3, 1'b0, 7'd0);
    pend = '1; mask = '1; step();
    chk("R1 R5 all masked", val3, idx3, 1'b0, 7'd0);
  endtask

  task automatic t_line0();
    clear_all(); pend[0] = 1'b1; setp(0, 9); step();
    chk("R6 line 0 real winner", val3, idx3, 1'b1, 7'd0);
  endtask

  task automatic t_class();
    clear_all(); pend[5] = 1; fast[5] = 1; pend[9] = 1;
    setp(5, 0); setp(9, 20); step();
    chk("R1 normal class", val3, idx3, 1'b1, 7'd9);
    class_fast = 1'b1; step();
    chk("R1 fast class", val3, idx3, 1'b1, 7'd5);
    pend[5] = 0; step();
    chk("R1 fast class empty", val3, idx3, 1'b0, 7'd0);
  endtask

  task automatic t_mask_prio();
    clear_all(); pend[40] = 1; pend[70] = 1; setp(40, 1); setp(70, 3);
    mask[40] = 1; step();
    chk("R1 masked line skipped", val3, idx3, 1'b1, 7'd70);
    mask[40] = 0; step();
    chk("R2 R4 lower value wins", val3, idx3, 1'b1, 7'd40);
  endtask

  task automatic t_tie();
    clear_all(); pend[3] = 1; pend[10] = 1; setp(3, 7); setp(10, 7); step();
    chk("R3 tie in bank", val3, idx3, 1'b1, 7'd10);
    pend[35] = 1; pend[90] = 1; setp(35, 7); setp(90, 7); step();
    chk("R3 tie across banks", val3, idx3, 1'b1, 7'd90);
    setp(35, 6); step();
    chk("R2 R4 bank 1 line", val3, idx3, 1'b1, 7'd35);
  endtask

  task automatic t_maxprio();
    clear_all(); pend[50] = 1; setp(50, 63); step();
    chk("R8 max value still wins", val3, idx3, 1'b1, 7'd50);
    pend[20] = 1; setp(20, 62); step();
    chk("R2 62 beats 63", val3, idx3, 1'b1, 7'd20);
  endtask

  task automatic t_banks();
    clear_all(); pend[10] = 1; pend[60] = 1; setp(10, 5); setp(60, 0); step();
    chk("R7 three banks", val3, idx3, 1'b1, 7'd60);
    chk("R7 one bank", val1, idx1, 1'b1, 7'd10);
    pend[10] = 0; step();
    chk("R7 one bank ignores bank 1", val1, idx1, 1'b0, 7'd0);
  endtask

  task automatic t_latency();
    clear_all(); pend[12] = 1; step();
    chk("R9 settle", val3, idx3, 1'b1, 7'd12);
    pend[12] = 0; pend[80] = 1; #1;
    chk("R9 held before edge", val3, idx3, 1'b1, 7'd12);
    step();
    chk("R9 updated after edge", val3, idx3, 1'b1, 7'd80);
    rst = 1'b1; step();
    chk("R9 sync reset", val3, idx3, 1'b0, 7'd0);
    rst = 1'b0; step();
    chk("R9 resume", val3, idx3, 1'b1, 7'd80);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_empty(); t_line0(); t_class(); t_mask_prio();
        t_tie(); t_maxprio(); t_banks(); t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule